// File: doc/BRIEF.md
# Reorder Buffer with Precise Commit

This block keeps program order for a small out-of-order core. Each dispatched instruction takes an entry at the tail of a six-entry circular buffer and receives that entry's index as its tag. Execution units complete instructions in any order by presenting the tag with a result and two status bits: an exception flag and a mispredicted-branch flag. Results wait inside their entry. The oldest entry leaves through a single architectural register-file write port, and only once it has completed.

If the oldest entry completed with an exception, it is not written back. Instead the block raises a one-cycle trap request that carries that instruction's PC and then empties itself. At that moment every older instruction has already been written to the register file and no younger one has.

A branch that completes as mispredicted discards every younger entry at the same clock edge. The tail then moves back to just behind the branch, and the branch itself retires later in the normal way.

Top module: `rob_inorder_commit`

## Requirements
- R1: After reset the buffer is empty: `disp_ready`=1, `rob_full`=0, `rf_we`=0, `trap_req`=0 and `disp_tag`=0.
- R2: A dispatch is accepted when `disp_valid` and `disp_ready` are both high. Each accepted dispatch takes the tag shown on `disp_tag` in that cycle. Tags count upward in program order from 0 to 5 and then wrap to 0.
- R3: With six entries occupied, `rob_full`=1 and `disp_ready`=0. A dispatch offered while the buffer is full allocates nothing, so the next accepted dispatch still receives the tag that was refused.
- R4: Entries retire strictly in allocation order, at most one per cycle. A retiring entry drives `rf_we`=1 for one cycle with its destination on `rf_waddr` and its written-back result on `rf_wdata`.
- R5: A completed entry never retires while any older entry is still incomplete. Writebacks may arrive in any tag order.
- R6: When the oldest entry completed with `wb_exc`=1, `rf_we` stays 0 for it. Instead `trap_req` is high for exactly one cycle with that entry's dispatch PC on `trap_pc`, and every older entry has already retired.
- R7: In the cycle after a trap request the buffer is empty. Younger entries are discarded even if they had completed, and the next dispatch receives tag 0.
- R8: An accepted writeback with `wb_mispred`=1 discards every younger entry at that clock edge. The next dispatch receives the tag that follows the branch (after 5 comes 0), and the branch itself still retires in order.
- R9: A writeback is ignored if its tag names an unoccupied or flushed entry, or an entry that has already completed. The stored result and the completion state are left unchanged.
- R10: `disp_ready` is 0 in any cycle in which a mispredicting writeback is accepted or `trap_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch stage offers an instruction |
| disp_dest | input | REG_W | Architectural destination register of the offered instruction |
| disp_pc | input | PC_W | PC of the offered instruction |
| disp_ready | output | 1 | Buffer accepts a dispatch this cycle |
| disp_tag | output | IDX_W | Tag assigned to the dispatch accepted this cycle |
| rob_full | output | 1 | All entries occupied |
| wb_valid | input | 1 | Writeback strobe from an execution unit |
| wb_tag | input | IDX_W | Entry tag being completed |
| wb_data | input | DATA_W | Result value |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_mispred | input | 1 | Branch resolved as mispredicted |
| rf_we | output | 1 | Architectural register-file write enable (retirement) |
| rf_waddr | output | REG_W | Register written at retirement |
| rf_wdata | output | DATA_W | Value written at retirement |
| trap_req | output | 1 | Precise exception request for the oldest entry |
| trap_pc | output | PC_W | PC of the excepting instruction |

## Verification
The main function is exercised with several completion orders. In the first, the youngest entries complete before the oldest, which separates in-order retirement from retirement on completion. In the second, a full buffer that straddles the tag wrap completes in reverse order, which checks pointer wrap together with full detection. In the third, a mispredicted branch sits in the middle with younger entries already completed, which separates an immediate flush from a flush at commit: a stale completed entry would show up as an extra retirement. Finally, an exception is placed behind one pending older instruction and ahead of one completed younger one, which checks that the trap is reported only at the head and that the younger result is discarded.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;

  // What the oldest entry does this cycle.
  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_TRAP   = 2'd2
  } head_act_e;

endpackage

// File: rtl/rob_rst_sync.sv
`timescale 1ns/1ps
module rob_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/rob_ptr_ctl.sv
`timescale 1ns/1ps
module rob_ptr_ctl #(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  input  logic             redirect,
  input  logic [IDX_W-1:0] redirect_idx,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

  // Pointer layout: {wrap, index}
  logic [IDX_W:0] head_q, head_n;
  logic [IDX_W:0] tail_q, tail_n;
  logic           ptr_en;
  logic           empty;
  logic           redir_wrap;

  function automatic logic [IDX_W:0] ptr_inc(input logic [IDX_W:0] p);
    if (p[IDX_W-1:0] == LAST) return {~p[IDX_W], {IDX_W{1'b0}}};
    else                      return {p[IDX_W], p[IDX_W-1:0] + ONE};
  endfunction

  // A tag at or past the head index lies in the head's lap, else in the next.
  assign redir_wrap = (redirect_idx >= head_q[IDX_W-1:0]) ? head_q[IDX_W] : ~head_q[IDX_W];

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    if (pop)      head_n = ptr_inc(head_q);
    if (push)     tail_n = ptr_inc(tail_q);
    if (redirect) tail_n = ptr_inc({redir_wrap, redirect_idx});
    if (clear) begin
      head_n = '0;
      tail_n = '0;
    end
  end

  assign ptr_en = push | pop | clear | redirect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (ptr_en) begin
      head_q <= head_n;
      tail_q <= tail_n;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign full     = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) && (head_q[IDX_W] != tail_q[IDX_W]);
  assign empty    = (head_q == tail_q);

  // R3: the control never pushes into a full ring
  p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R4: retirement only from a non-empty ring
  p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R8: after a flush the tail sits right behind the branch
  p_redirect_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (tail_idx == (($past(redirect_idx) == LAST) ? '0 : $past(redirect_idx) + ONE)));

endmodule

// File: rtl/rob_age_mask.sv
`timescale 1ns/1ps
module rob_age_mask #(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3
) (
  input  logic             en,
  input  logic [IDX_W-1:0] head_idx,
  input  logic [IDX_W-1:0] pivot_idx,
  input  logic [DEPTH-1:0] valid_vec,
  output logic [DEPTH-1:0] younger
);

  localparam logic [IDX_W:0] DEPTH_P = (IDX_W+1)'(DEPTH);

  // Distance of an index from the head in program order.
  function automatic logic [IDX_W:0] age_of(input logic [IDX_W-1:0] i,
                                            input logic [IDX_W-1:0] h);
    if (i >= h) return {1'b0, i - h};
    else        return {1'b0, i} + DEPTH_P - {1'b0, h};
  endfunction

  logic [IDX_W:0] pivot_age;
  assign pivot_age = age_of(pivot_idx, head_idx);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    localparam logic [IDX_W-1:0] IDX = IDX_W'(g);
    assign younger[g] = en && valid_vec[g] && (age_of(IDX, head_idx) > pivot_age);
  end

endmodule

// File: rtl/rob_entry_array.sv
`timescale 1ns/1ps
module rob_entry_array #(
  parameter int DEPTH  = 6,
  parameter int IDX_W  = 3,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic              wb_we,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_exc,
  input  logic [DEPTH-1:0]  kill_mask,
  input  logic              retire_we,
  input  logic [IDX_W-1:0]  retire_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DEPTH-1:0]  valid_vec,
  output logic [DEPTH-1:0]  done_vec,
  output logic              rd_exc,
  output logic [REG_W-1:0]  rd_dest,
  output logic [DATA_W-1:0] rd_data,
  output logic [PC_W-1:0]   rd_pc
);

  logic [DEPTH-1:0]  exc_vec;
  logic [REG_W-1:0]  dest_arr [DEPTH];
  logic [DATA_W-1:0] data_arr [DEPTH];
  logic [PC_W-1:0]   pc_arr   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [IDX_W-1:0] IDX = IDX_W'(g);

    logic              v_q, v_n;
    logic              d_q, d_n;
    logic              x_q, x_n;
    logic [REG_W-1:0]  dest_q;
    logic [DATA_W-1:0] data_q;
    logic [PC_W-1:0]   pc_q;
    logic              sel_alloc, sel_wb, sel_drop;

    assign sel_alloc = alloc_we && (alloc_idx == IDX);
    assign sel_wb    = wb_we && (wb_idx == IDX);
    assign sel_drop  = clear || kill_mask[g] || (retire_we && (retire_idx == IDX));

    always_comb begin
      v_n = v_q;
      d_n = d_q;
      x_n = x_q;
      if (sel_drop) v_n = 1'b0;
      if (sel_alloc) begin
        v_n = 1'b1;
        d_n = 1'b0;
        x_n = 1'b0;
      end else if (sel_wb) begin
        d_n = 1'b1;
        x_n = wb_exc;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        x_q <= 1'b0;
      end else begin
        v_q <= v_n;
        d_q <= d_n;
        x_q <= x_n;
      end
    end

    // Payload: loaded under enable, no reset needed
    always_ff @(posedge clk) begin
      if (sel_alloc) begin
        dest_q <= alloc_dest;
        pc_q   <= alloc_pc;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_wb) data_q <= wb_data;
    end

    assign valid_vec[g] = v_q;
    assign done_vec[g]  = d_q;
    assign exc_vec[g]   = x_q;
    assign dest_arr[g]  = dest_q;
    assign data_arr[g]  = data_q;
    assign pc_arr[g]    = pc_q;
  end

  assign rd_exc  = exc_vec[rd_idx];
  assign rd_dest = dest_arr[rd_idx];
  assign rd_data = data_arr[rd_idx];
  assign rd_pc   = pc_arr[rd_idx];

  // R2: a new instruction never lands on a live entry
  p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |-> !valid_vec[alloc_idx]);

  // R9: completion only for a live, still pending entry
  p_wb_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (valid_vec[wb_idx] && !done_vec[wb_idx]));

  // R5: only completed live entries leave
  p_retire_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_we |-> (valid_vec[retire_idx] && done_vec[retire_idx]));

endmodule

// File: rtl/rob_inorder_commit.sv
`timescale 1ns/1ps
module rob_inorder_commit
  import rob_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [REG_W-1:0]  disp_dest,
  input  logic [PC_W-1:0]   disp_pc,
  output logic              disp_ready,
  output logic [IDX_W-1:0]  disp_tag,
  output logic              rob_full,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_exc,
  input  logic              wb_mispred,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              trap_req,
  output logic [PC_W-1:0]   trap_pc
);

  localparam logic [IDX_W:0] DEPTH_P = (IDX_W+1)'(DEPTH);

  logic             rst_q_n;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic             full;
  logic [DEPTH-1:0] valid_vec, done_vec, kill_mask;
  logic             head_exc;
  logic             tag_ok, wb_live, redirect;
  logic             push, pop, clear;
  head_act_e        head_act;

  rob_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // Decide what the oldest entry does
  always_comb begin
    head_act = HEAD_WAIT;
    if (valid_vec[head_idx] && done_vec[head_idx])
      head_act = head_exc ? HEAD_TRAP : HEAD_RETIRE;
  end

  assign pop   = (head_act == HEAD_RETIRE);
  assign clear = (head_act == HEAD_TRAP);

  // Writeback qualification
  assign tag_ok   = ({1'b0, wb_tag} < DEPTH_P);
  assign wb_live  = wb_valid && tag_ok && valid_vec[wb_tag] && !done_vec[wb_tag] && !clear;
  assign redirect = wb_live && wb_mispred;

  // Dispatch gating
  assign disp_ready = !full && !redirect && !clear;
  assign push       = disp_valid && disp_ready;

  rob_ptr_ctl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .push         (push),
    .pop          (pop),
    .clear        (clear),
    .redirect     (redirect),
    .redirect_idx (wb_tag),
    .head_idx     (head_idx),
    .tail_idx     (tail_idx),
    .full         (full)
  );

  rob_age_mask #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_age (
    .en        (redirect),
    .head_idx  (head_idx),
    .pivot_idx (wb_tag),
    .valid_vec (valid_vec),
    .younger   (kill_mask)
  );

  rob_entry_array #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)
  ) u_ent (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .clear      (clear),
    .alloc_we   (push),
    .alloc_idx  (tail_idx),
    .alloc_dest (disp_dest),
    .alloc_pc   (disp_pc),
    .wb_we      (wb_live),
    .wb_idx     (wb_tag),
    .wb_data    (wb_data),
    .wb_exc     (wb_exc),
    .kill_mask  (kill_mask),
    .retire_we  (pop),
    .retire_idx (head_idx),
    .rd_idx     (head_idx),
    .valid_vec  (valid_vec),
    .done_vec   (done_vec),
    .rd_exc     (head_exc),
    .rd_dest    (rf_waddr),
    .rd_data    (rf_wdata),
    .rd_pc      (trap_pc)
  );

  assign rf_we    = pop;
  assign trap_req = clear;
  assign disp_tag = tail_idx;
  assign rob_full = full;

  // R7: a trap leaves the ring empty on the next cycle
  p_trap_clears_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    trap_req |=> (!rf_we && !trap_req && (disp_tag == '0)));

endmodule

// File: tb/rob_inorder_commit_test.sv
`timescale 1ns/1ps
module rob_inorder_commit_test;

  localparam int DEPTH  = 6;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam int PC_W   = 32;
  localparam int IDX_W  = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              disp_valid;
  logic [REG_W-1:0]  disp_dest;
  logic [PC_W-1:0]   disp_pc;
  logic              disp_ready;
  logic [IDX_W-1:0]  disp_tag;
  logic              rob_full;
  logic              wb_valid;
  logic [IDX_W-1:0]  wb_tag;
  logic [DATA_W-1:0] wb_data;
  logic              wb_exc;
  logic              wb_mispred;
  logic              rf_we;
  logic [REG_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  logic              trap_req;
  logic [PC_W-1:0]   trap_pc;

  int vectors  = 0;
  int fails    = 0;
  bit finished = 1'b0;

  typedef struct {
    bit               trap;
    logic [REG_W-1:0] dst;
    logic [31:0]      val;
    string            req;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  rob_inorder_commit #(
    .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_pc(disp_pc),
    .disp_ready(disp_ready), .disp_tag(disp_tag), .rob_full(rob_full),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .wb_exc(wb_exc), .wb_mispred(wb_mispred),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .trap_req(trap_req), .trap_pc(trap_pc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic expect_retire(input logic [REG_W-1:0] d, input logic [31:0] v, input string req);
    exp_t e;
    e.trap = 1'b0; e.dst = d; e.val = v; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic expect_trap(input logic [31:0] pc, input string req);
    exp_t e;
    e.trap = 1'b1; e.dst = '0; e.val = pc; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic disp(input logic [REG_W-1:0] d, input logic [31:0] pc,
                      output logic [IDX_W-1:0] tag, output logic rdy);
    @(negedge clk);
    disp_valid = 1'b1; disp_dest = d; disp_pc = pc;
    #1;
    tag = disp_tag; rdy = disp_ready;
    @(posedge clk);
    #1;
    disp_valid = 1'b0;
  endtask

  task automatic wb(input logic [IDX_W-1:0] t, input logic [31:0] v,
                    input logic x, input logic m);
    @(negedge clk);
    wb_valid = 1'b1; wb_tag = t; wb_data = v; wb_exc = x; wb_mispred = m;
    @(posedge clk);
    #1;
    wb_valid = 1'b0; wb_exc = 1'b0; wb_mispred = 1'b0;
  endtask

  // Mispredicting writeback with a dispatch offered in the same cycle
  task automatic wb_misp_with_disp(input logic [IDX_W-1:0] t, input logic [31:0] v,
                                   output logic rdy);
    @(negedge clk);
    wb_valid = 1'b1; wb_tag = t; wb_data = v; wb_exc = 1'b0; wb_mispred = 1'b1;
    disp_valid = 1'b1; disp_dest = 5'd30; disp_pc = 32'hEEE0;
    #1;
    rdy = disp_ready;
    @(posedge clk);
    #1;
    wb_valid = 1'b0; wb_mispred = 1'b0; disp_valid = 1'b0;
  endtask

  // Scoreboard monitor: retirement and trap events against the queue
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && !finished && (rf_we || trap_req)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, rf_we ? "R5" : "R6", "unexpected retire or trap",
            {trap_req, rf_we, 3'b0, rf_waddr}, 64'h0);
      end else begin
        e = exp_q.pop_front();
        chk((trap_req == e.trap) && (rf_we == !e.trap), e.req, "event kind {trap,we}",
            {trap_req, rf_we}, {e.trap, !e.trap});
        if (e.trap) begin
          chk(trap_pc == e.val, e.req, "trap pc", trap_pc, e.val);
        end else begin
          chk(rf_waddr == e.dst, e.req, "rf_waddr", rf_waddr, e.dst);
          chk(rf_wdata == e.val, e.req, "rf_wdata", rf_wdata, e.val);
        end
      end
    end
    if (rst_n && !finished && trap_req)
      chk(!disp_ready, "R10", "disp_ready during trap", disp_ready, 0);
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [IDX_W-1:0] tg;
    logic             rd;

    rst_n = 1'b0;
    disp_valid = 1'b0; disp_dest = '0; disp_pc = '0;
    wb_valid = 1'b0; wb_tag = '0; wb_data = '0; wb_exc = 1'b0; wb_mispred = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: empty after reset
    chk(disp_ready == 1'b1, "R1", "disp_ready", disp_ready, 1);
    chk(rob_full == 1'b0,   "R1", "rob_full", rob_full, 0);
    chk(rf_we == 1'b0,      "R1", "rf_we", rf_we, 0);
    chk(trap_req == 1'b0,   "R1", "trap_req", trap_req, 0);
    chk(disp_tag == '0,     "R1", "disp_tag", disp_tag, 0);

    // R2/R5: out-of-order completion, in-order retirement
    disp(5'd1, 32'h100, tg, rd); chk(tg == 3'd0 && rd, "R2", "tag first", tg, 0);
    disp(5'd2, 32'h104, tg, rd); chk(tg == 3'd1, "R2", "tag second", tg, 1);
    disp(5'd3, 32'h108, tg, rd); chk(tg == 3'd2, "R2", "tag third", tg, 2);
    wb(3'd2, 32'hC3, 1'b0, 1'b0);
    wb(3'd1, 32'hB2, 1'b0, 1'b0);
    idle(3);   // nothing may retire: the head is still pending (R5)
    expect_retire(5'd1, 32'hA1, "R4");
    expect_retire(5'd2, 32'hB2, "R5");
    expect_retire(5'd3, 32'hC3, "R5");
    wb(3'd0, 32'hA1, 1'b0, 1'b0);
    idle(6);
    chk(exp_q.size() == 0, "R4", "pending retirements", exp_q.size(), 0);

    // R2/R3: fill across the wrap, reverse completion
    for (int k = 0; k < 6; k++) begin
      disp(5'(10 + k), 32'h400 + 32'(4 * k), tg, rd);
      chk(tg == 3'((3 + k) % 6), "R2", "tag across wrap", tg, (3 + k) % 6);
    end
    chk(rob_full == 1'b1,   "R3", "rob_full when six live", rob_full, 1);
    chk(disp_ready == 1'b0, "R3", "disp_ready when full", disp_ready, 0);
    disp(5'd31, 32'hDEAD, tg, rd);
    chk(rd == 1'b0, "R3", "refused dispatch ready", rd, 0);
    for (int k = 0; k < 6; k++) expect_retire(5'(10 + k), 32'h5000 + 32'(k), "R4");
    for (int k = 5; k >= 0; k--) wb(3'((3 + k) % 6), 32'h5000 + 32'(k), 1'b0, 1'b0);
    idle(10);
    chk(exp_q.size() == 0, "R4", "pending retirements after fill", exp_q.size(), 0);

    // R8/R9/R10: mispredict flush with completed younger entries
    disp(5'd4, 32'h200, tg, rd); chk(tg == 3'd3, "R3", "refused dispatch took no entry", tg, 3);
    disp(5'd0, 32'h204, tg, rd); chk(tg == 3'd4, "R2", "branch tag", tg, 4);
    disp(5'd6, 32'h208, tg, rd);
    disp(5'd7, 32'h20C, tg, rd); chk(tg == 3'd0, "R2", "tag wraps to 0", tg, 0);
    wb(3'd5, 32'hBAD5, 1'b0, 1'b0);
    wb(3'd0, 32'hBAD0, 1'b0, 1'b0);
    wb_misp_with_disp(3'd4, 32'h77, rd);
    chk(rd == 1'b0, "R10", "disp_ready with mispredict", rd, 0);
    disp(5'd8, 32'h210, tg, rd);
    chk(tg == 3'd5, "R8", "tag after flush", tg, 5);
    wb(3'd0, 32'hBAD1, 1'b0, 1'b0);   // flushed entry: ignored (R9)
    expect_retire(5'd4, 32'h11, "R8");
    expect_retire(5'd0, 32'h77, "R8");
    expect_retire(5'd8, 32'h22, "R8");
    wb(3'd3, 32'h11, 1'b0, 1'b0);
    wb(3'd5, 32'h22, 1'b0, 1'b0);
    idle(8);
    chk(exp_q.size() == 0, "R8", "pending retirements after flush", exp_q.size(), 0);

    disp(5'd12, 32'h214, tg, rd);
    chk(tg == 3'd0, "R9", "reused flushed tag", tg, 0);
    idle(4);   // stale completion must not retire it (R9)
    expect_retire(5'd12, 32'h33, "R9");
    wb(3'd0, 32'h33, 1'b0, 1'b0);
    idle(4);

    disp(5'd13, 32'h218, tg, rd); chk(tg == 3'd1, "R2", "tag P", tg, 1);
    disp(5'd14, 32'h21C, tg, rd); chk(tg == 3'd2, "R2", "tag Q", tg, 2);
    wb(3'd2, 32'h44, 1'b0, 1'b0);
    wb(3'd2, 32'h55, 1'b0, 1'b0);   // second completion: ignored (R9)
    expect_retire(5'd13, 32'h66, "R9");
    expect_retire(5'd14, 32'h44, "R9");
    wb(3'd1, 32'h66, 1'b0, 1'b0);
    idle(6);
    chk(exp_q.size() == 0, "R9", "pending retirements after duplicate", exp_q.size(), 0);

    // R6/R7: exception behind a pending older entry
    disp(5'd15, 32'h300, tg, rd); chk(tg == 3'd3, "R2", "tag E0", tg, 3);
    disp(5'd16, 32'h304, tg, rd);
    disp(5'd17, 32'h308, tg, rd);
    wb(3'd5, 32'h88, 1'b0, 1'b0);
    expect_retire(5'd15, 32'h99, "R6");
    expect_trap(32'h304, "R6");
    wb(3'd4, 32'h0, 1'b1, 1'b0);
    wb(3'd3, 32'h99, 1'b0, 1'b0);
    idle(6);   // completed younger entry must never retire (R7)
    chk(exp_q.size() == 0, "R6", "pending events after trap", exp_q.size(), 0);
    disp(5'd18, 32'h400, tg, rd);
    chk(tg == 3'd0, "R7", "tag after trap", tg, 0);
    expect_retire(5'd18, 32'hAA, "R7");
    wb(3'd0, 32'hAA, 1'b0, 1'b0);
    idle(4);
    chk(exp_q.size() == 0, "R7", "pending retirements at end", exp_q.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule